// File: doc/BRIEF.md
# Road-to-Hit Data Organizer

This block sits next to a coarse pattern matcher in a track-finding pipeline. While an event is being read in, every incoming hit arrives with its layer number, its coarse superstrip identifier and its full-resolution data word. The organizer keeps the full-resolution word in local storage and passes only the layer and superstrip identifier on to the matcher, one cycle later. Storage is organised as one bin per (layer, superstrip). Each bin is a chain of hit entries reached through a head-pointer table, so a bin may hold any number of hits up to a configurable limit.

When the matcher reports a matched road, the organizer turns the road number into one superstrip per layer through a writable lookup table. It then walks the bin of each of those superstrips and collects every stored hit. A combiner then lists every track candidate that takes exactly one hit from each layer, one candidate per clock. A layer whose bin is empty contributes a single "missing" placeholder, so a road matched on a majority of layers still produces candidates. An end-of-event strobe empties all bins at once by clearing their valid flags. Hits that arrive after a bin is full are dropped and counted.

Top module: `road_hit_organizer`

## Requirements
- R1: One cycle after a cycle with `hit_valid` high, `fwd_valid` is high and `fwd_layer`/`fwd_ssid` equal that hit's layer and superstrip. `fwd_valid` is low one cycle after a cycle with `hit_valid` low.
- R2: A road number presented on `road_id` selects, for each layer `l`, the superstrip written earlier with `lut_we` high, `lut_road` equal to that road and `lut_layer` equal to `l`.
- R3: For each layer, the candidates of a road contain exactly the hits stored in that layer's selected superstrip during the current event. Hits in any other superstrip of that layer never appear.
- R4: Within one layer, stored hits are indexed newest first: index 0 is the most recently stored hit of that bin.
- R5: After a road is accepted, the block emits the product over layers of max(1, hits in bin) candidates on consecutive cycles, with `cand_valid` high. The index of the last layer advances fastest (odometer order, layer 0 slowest). `cand_last` is high only with the final candidate.
- R6: A layer whose selected bin is empty contributes one placeholder. Its bit in `cand_miss` is 1 and its `HIT_W`-bit field in `cand_hits` is zero. Layer `l` occupies bits `[l*HIT_W +: HIT_W]` of `cand_hits`, and bit `l` of `cand_miss`.
- R7: A bin keeps at most `SS_LIMIT` hits per event, namely the first ones to arrive. Each later hit for that bin, and each hit that arrives when hit storage is full, is dropped and increments `ovf_count` by one. The count is cumulative from reset.
- R8: A cycle with `eoe` high empties every bin, so hits stored before it are never retrieved afterwards. A hit presented in the same cycle belongs to the new event.
- R9: `road_ready` is high only while no road is being processed. A road is accepted in a cycle where `road_valid` and `road_ready` are both high. Right after reset, `road_ready` is 1, `cand_valid` is 0, `fwd_valid` is 0 and `ovf_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Incoming hit strobe |
| hit_layer | input | LAY_W | Layer of the hit |
| hit_ssid | input | SS_W | Coarse superstrip of the hit |
| hit_data | input | HIT_W | Full-resolution hit word |
| eoe | input | 1 | End-of-event strobe, empties all bins |
| fwd_valid | output | 1 | Superstrip forwarded to the matcher |
| fwd_layer | output | LAY_W | Forwarded layer |
| fwd_ssid | output | SS_W | Forwarded superstrip |
| lut_we | input | 1 | Lookup table write strobe |
| lut_road | input | ROAD_W | Road written |
| lut_layer | input | LAY_W | Layer written |
| lut_ssid | input | SS_W | Superstrip stored for that road and layer |
| road_valid | input | 1 | Matched road offered |
| road_id | input | ROAD_W | Matched road number |
| road_ready | output | 1 | Organizer idle, road can be accepted |
| cand_valid | output | 1 | Track candidate valid |
| cand_last | output | 1 | Final candidate of the road |
| cand_hits | output | N_LAYERS*HIT_W | One hit word per layer, layer 0 in the low bits |
| cand_miss | output | N_LAYERS | Placeholder flag per layer |
| ovf_count | output | OVF_W | Dropped-hit counter |

## Verification
On every cycle, the assertions check four things. Forwarding follows the hit strobe by exactly one cycle. `road_ready` and a candidate are never high together. A candidate stream, once started, runs without gaps until `cand_last`, and every per-layer index stays inside that layer's bin. The drop counter moves only after a hit strobe. The content and order of the candidates can only be shown by the bench's event sweep: newest-first order inside a bin, odometer order across layers, the placeholder for empty bins, and the exclusion of other superstrips. The same holds for the per-bin limit, the lookup mapping of every road, and the clearing of bins at the end of an event.

// File: rtl/rho_pkg.sv
package rho_pkg;
    typedef enum logic [2:0] {
        RHO_IDLE,
        RHO_LOAD,
        RHO_WALK,
        RHO_START,
        RHO_COMB
    } rho_state_e;
endpackage

// File: rtl/rho_hit_store.sv
module rho_hit_store #(
    parameter int N_LAYERS = 3,
    parameter int SS_W     = 3,
    parameter int HIT_W    = 8,
    parameter int DEPTH    = 16,
    parameter int SS_LIMIT = 3,
    parameter int OVF_W    = 8,
    localparam int LAY_W   = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(SS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [LAY_W-1:0] wr_layer,
    input  logic [SS_W-1:0]  wr_ssid,
    input  logic [HIT_W-1:0] wr_data,
    input  logic             eoe,
    input  logic [LAY_W-1:0] rd_layer,
    input  logic [SS_W-1:0]  rd_ssid,
    input  logic [AW-1:0]    rd_ptr,
    output logic             head_vld_o,
    output logic [AW-1:0]    head_ptr_o,
    output logic [CW-1:0]    head_cnt_o,
    output logic [HIT_W-1:0] rd_data_o,
    output logic [AW-1:0]    rd_next_o,
    output logic [OVF_W-1:0] ovf_cnt_o
);
    localparam int NSS = 1 << SS_W;
    localparam int NE  = N_LAYERS * NSS;
    localparam int EW  = (NE > 1) ? $clog2(NE) : 1;

    typedef struct packed {
        logic [NE-1:0]                vld;
        logic [NE-1:0][AW-1:0]        ptr;
        logic [NE-1:0][CW-1:0]        cnt;
        logic [DEPTH-1:0][HIT_W-1:0]  data;
        logic [DEPTH-1:0][AW-1:0]     nxt;
        logic [AW:0]                  wptr;
        logic [OVF_W-1:0]             ovf;
    } store_t;

    store_t s_d, s_q;
    logic [EW-1:0] widx, ridx;
    logic [CW-1:0] ccnt;

    always_comb begin
        s_d  = s_q;
        widx = EW'(int'(wr_layer) * NSS + int'(wr_ssid));
        if (eoe) begin
            s_d.vld  = '0;
            s_d.wptr = '0;
        end
        ccnt = s_d.vld[widx] ? s_d.cnt[widx] : '0;
        if (wr_valid && (int'(wr_layer) < N_LAYERS)) begin
            if ((int'(ccnt) < SS_LIMIT) && (int'(s_d.wptr) < DEPTH)) begin
                s_d.data[s_d.wptr[AW-1:0]] = wr_data;
                s_d.nxt[s_d.wptr[AW-1:0]]  = s_d.vld[widx] ? s_d.ptr[widx] : '0;
                s_d.ptr[widx]              = s_d.wptr[AW-1:0];
                s_d.cnt[widx]              = ccnt + 1'b1;
                s_d.vld[widx]              = 1'b1;
                s_d.wptr                   = s_d.wptr + 1'b1;
            end else begin
                s_d.ovf = s_q.ovf + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ridx       = EW'(int'(rd_layer) * NSS + int'(rd_ssid));
    assign head_vld_o = s_q.vld[ridx];
    assign head_ptr_o = s_q.ptr[ridx];
    assign head_cnt_o = s_q.cnt[ridx];
    assign rd_data_o  = s_q.data[rd_ptr];
    assign rd_next_o  = s_q.nxt[rd_ptr];
    assign ovf_cnt_o  = s_q.ovf;

    // R7: drop counter only moves after a hit strobe, by one
    a_r7_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt_o != $past(ovf_cnt_o)) |-> ($past(wr_valid) && (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1)));
endmodule

// File: rtl/rho_road_lut.sv
module rho_road_lut #(
    parameter int N_LAYERS = 3,
    parameter int SS_W     = 3,
    parameter int ROAD_W   = 3,
    localparam int LAY_W   = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ROAD_W-1:0]            wr_road,
    input  logic [LAY_W-1:0]             wr_layer,
    input  logic [SS_W-1:0]              wr_ssid,
    input  logic [ROAD_W-1:0]            rd_road,
    output logic [N_LAYERS-1:0][SS_W-1:0] rd_ssids
);
    localparam int NR  = 1 << ROAD_W;
    localparam int NT  = NR * N_LAYERS;
    localparam int TW  = $clog2(NT);

    typedef struct packed {
        logic [NT-1:0][SS_W-1:0] tbl;
    } lut_t;

    lut_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we && (int'(wr_layer) < N_LAYERS))
            s_d.tbl[TW'(int'(wr_road) * N_LAYERS + int'(wr_layer))] = wr_ssid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int l = 0; l < N_LAYERS; l++)
            rd_ssids[l] = s_q.tbl[TW'(int'(rd_road) * N_LAYERS + l)];
    end
endmodule

// File: rtl/rho_combiner.sv
module rho_combiner #(
    parameter int N_LAYERS = 3,
    parameter int SS_LIMIT = 3,
    localparam int CW      = $clog2(SS_LIMIT + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [N_LAYERS-1:0][CW-1:0] cnt_i,
    output logic                        valid_o,
    output logic                        last_o,
    output logic [N_LAYERS-1:0][CW-1:0] idx_o,
    output logic [N_LAYERS-1:0]         miss_o
);
    typedef struct packed {
        logic                        busy;
        logic [N_LAYERS-1:0][CW-1:0] cnt;
        logic [N_LAYERS-1:0][CW-1:0] idx;
    } comb_t;

    comb_t s_d, s_q;
    logic [N_LAYERS-1:0][CW-1:0] top;
    logic at_end, carry;

    always_comb begin
        at_end = 1'b1;
        for (int l = 0; l < N_LAYERS; l++) begin
            top[l] = (s_q.cnt[l] == '0) ? '0 : s_q.cnt[l] - 1'b1;
            if (s_q.idx[l] != top[l]) at_end = 1'b0;
        end
        s_d   = s_q;
        carry = 1'b1;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = cnt_i;
            s_d.idx  = '0;
        end else if (s_q.busy) begin
            if (at_end) begin
                s_d.busy = 1'b0;
            end else begin
                for (int l = N_LAYERS - 1; l >= 0; l--) begin
                    if (carry) begin
                        if (s_q.idx[l] == top[l]) begin
                            s_d.idx[l] = '0;
                        end else begin
                            s_d.idx[l] = s_q.idx[l] + 1'b1;
                            carry      = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.busy;
    assign last_o  = s_q.busy && at_end;
    assign idx_o   = s_q.idx;
    always_comb begin
        for (int l = 0; l < N_LAYERS; l++) miss_o[l] = (s_q.cnt[l] == '0);
    end

    // R5: final flag only on a valid candidate
    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);
    // R5: candidate stream has no gaps before the final one
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    for (genvar g = 0; g < N_LAYERS; g++) begin : g_rng
        // R6: per-layer index stays within the bin (placeholder counts as one)
        a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> ((s_q.cnt[g] == '0) ? (idx_o[g] == '0) : (idx_o[g] < s_q.cnt[g])));
    end
endmodule

// File: rtl/road_hit_organizer.sv
module road_hit_organizer #(
    parameter int N_LAYERS = 3,
    parameter int SS_W     = 3,
    parameter int HIT_W    = 8,
    parameter int DEPTH    = 16,
    parameter int SS_LIMIT = 3,
    parameter int ROAD_W   = 3,
    parameter int OVF_W    = 8,
    localparam int LAY_W   = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit_valid,
    input  logic [LAY_W-1:0]            hit_layer,
    input  logic [SS_W-1:0]             hit_ssid,
    input  logic [HIT_W-1:0]            hit_data,
    input  logic                        eoe,
    output logic                        fwd_valid,
    output logic [LAY_W-1:0]            fwd_layer,
    output logic [SS_W-1:0]             fwd_ssid,
    input  logic                        lut_we,
    input  logic [ROAD_W-1:0]           lut_road,
    input  logic [LAY_W-1:0]            lut_layer,
    input  logic [SS_W-1:0]             lut_ssid,
    input  logic                        road_valid,
    input  logic [ROAD_W-1:0]           road_id,
    output logic                        road_ready,
    output logic                        cand_valid,
    output logic                        cand_last,
    output logic [N_LAYERS*HIT_W-1:0]   cand_hits,
    output logic [N_LAYERS-1:0]         cand_miss,
    output logic [OVF_W-1:0]            ovf_count
);
    import rho_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(SS_LIMIT + 1);

    typedef struct packed {
        rho_state_e                                  st;
        logic [LAY_W-1:0]                            layer;
        logic [N_LAYERS-1:0][SS_W-1:0]               ssid;
        logic [AW-1:0]                               cur;
        logic [CW-1:0]                               n;
        logic [N_LAYERS-1:0][CW-1:0]                 cnts;
        logic [N_LAYERS-1:0][SS_LIMIT-1:0][HIT_W-1:0] hb;
        logic                                        fwd_v;
        logic [LAY_W-1:0]                            fwd_l;
        logic [SS_W-1:0]                             fwd_s;
    } org_t;

    org_t s_d, s_q;
    logic                          adv;
    logic                          h_vld;
    logic [AW-1:0]                 h_ptr, r_next;
    logic [CW-1:0]                 h_cnt;
    logic [HIT_W-1:0]              r_data;
    logic [N_LAYERS-1:0][SS_W-1:0] lut_ssids;
    logic                          c_valid, c_last;
    logic [N_LAYERS-1:0][CW-1:0]   c_idx;
    logic [N_LAYERS-1:0]           c_miss;

    rho_hit_store #(
        .N_LAYERS(N_LAYERS), .SS_W(SS_W), .HIT_W(HIT_W),
        .DEPTH(DEPTH), .SS_LIMIT(SS_LIMIT), .OVF_W(OVF_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(hit_valid), .wr_layer(hit_layer), .wr_ssid(hit_ssid), .wr_data(hit_data),
        .eoe(eoe),
        .rd_layer(s_q.layer), .rd_ssid(s_q.ssid[s_q.layer]), .rd_ptr(s_q.cur),
        .head_vld_o(h_vld), .head_ptr_o(h_ptr), .head_cnt_o(h_cnt),
        .rd_data_o(r_data), .rd_next_o(r_next), .ovf_cnt_o(ovf_count)
    );

    rho_road_lut #(.N_LAYERS(N_LAYERS), .SS_W(SS_W), .ROAD_W(ROAD_W)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .we(lut_we), .wr_road(lut_road), .wr_layer(lut_layer), .wr_ssid(lut_ssid),
        .rd_road(road_id), .rd_ssids(lut_ssids)
    );

    rho_combiner #(.N_LAYERS(N_LAYERS), .SS_LIMIT(SS_LIMIT)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .start(s_q.st == RHO_START), .cnt_i(s_q.cnts),
        .valid_o(c_valid), .last_o(c_last), .idx_o(c_idx), .miss_o(c_miss)
    );

    always_comb begin
        s_d       = s_q;
        adv       = 1'b0;
        s_d.fwd_v = hit_valid;
        s_d.fwd_l = hit_layer;
        s_d.fwd_s = hit_ssid;
        case (s_q.st)
            RHO_IDLE: begin
                if (road_valid) begin
                    s_d.ssid  = lut_ssids;
                    s_d.layer = '0;
                    s_d.st    = RHO_LOAD;
                end
            end
            RHO_LOAD: begin
                if (h_vld && (h_cnt != '0)) begin
                    s_d.cur              = h_ptr;
                    s_d.n                = '0;
                    s_d.cnts[s_q.layer]  = h_cnt;
                    s_d.st               = RHO_WALK;
                end else begin
                    s_d.cnts[s_q.layer]  = '0;
                    adv                  = 1'b1;
                end
            end
            RHO_WALK: begin
                s_d.hb[s_q.layer][s_q.n] = r_data;
                s_d.cur                  = r_next;
                s_d.n                    = s_q.n + 1'b1;
                if (s_q.n + 1'b1 == s_q.cnts[s_q.layer]) adv = 1'b1;
            end
            RHO_START: s_d.st = RHO_COMB;
            RHO_COMB:  if (c_valid && c_last) s_d.st = RHO_IDLE;
            default:   s_d.st = RHO_IDLE;
        endcase
        if (adv) begin
            if (int'(s_q.layer) == N_LAYERS - 1) begin
                s_d.st = RHO_START;
            end else begin
                s_d.layer = s_q.layer + 1'b1;
                s_d.st    = RHO_LOAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fwd_valid  = s_q.fwd_v;
    assign fwd_layer  = s_q.fwd_l;
    assign fwd_ssid   = s_q.fwd_s;
    assign road_ready = (s_q.st == RHO_IDLE);
    assign cand_valid = c_valid;
    assign cand_last  = c_last;
    assign cand_miss  = c_miss;

    always_comb begin
        for (int l = 0; l < N_LAYERS; l++)
            cand_hits[l*HIT_W +: HIT_W] = c_miss[l] ? '0 : s_q.hb[l][c_idx[l]];
    end

    // R1: superstrip is forwarded one cycle after the hit
    a_r1_forward: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> (fwd_valid && fwd_layer == $past(hit_layer) && fwd_ssid == $past(hit_ssid)));
    // R9: no new road accepted while candidates are being emitted
    a_r9_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> !road_ready);
    // R9: an accepted road takes the organizer out of idle
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready) |=> !road_ready);
endmodule

// File: tb/test_road_hit_organizer.sv
module test_road_hit_organizer;
    localparam int NL = 3;
    localparam int SW = 3;
    localparam int HW = 8;
    localparam int RW = 3;
    localparam int OW = 8;
    localparam int LIM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_valid = 1'b0;
    logic [1:0] hit_layer = '0;
    logic [SW-1:0] hit_ssid = '0;
    logic [HW-1:0] hit_data = '0;
    logic eoe = 1'b0;
    logic fwd_valid;
    logic [1:0] fwd_layer;
    logic [SW-1:0] fwd_ssid;
    logic lut_we = 1'b0;
    logic [RW-1:0] lut_road = '0;
    logic [1:0] lut_layer = '0;
    logic [SW-1:0] lut_ssid = '0;
    logic road_valid = 1'b0;
    logic [RW-1:0] road_id = '0;
    logic road_ready, cand_valid, cand_last;
    logic [NL*HW-1:0] cand_hits;
    logic [NL-1:0] cand_miss;
    logic [OW-1:0] ovf_count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    road_hit_organizer i_road_hit_organizer (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_layer(hit_layer), .hit_ssid(hit_ssid), .hit_data(hit_data),
        .eoe(eoe),
        .fwd_valid(fwd_valid), .fwd_layer(fwd_layer), .fwd_ssid(fwd_ssid),
        .lut_we(lut_we), .lut_road(lut_road), .lut_layer(lut_layer), .lut_ssid(lut_ssid),
        .road_valid(road_valid), .road_id(road_id), .road_ready(road_ready),
        .cand_valid(cand_valid), .cand_last(cand_last),
        .cand_hits(cand_hits), .cand_miss(cand_miss), .ovf_count(ovf_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [HW-1:0] hd(input int ev, input int l, input int i);
        return {2'(ev), 2'(l), 3'(i), 1'b1};
    endfunction

    function automatic int lut_of(input int r, input int l);
        return (r + 3 * l) % 8;
    endfunction

    task automatic put_hit(input int l, input int s, input logic [HW-1:0] d);
        hit_valid = 1'b1;
        hit_layer = 2'(l);
        hit_ssid  = SW'(s);
        hit_data  = d;
        @(negedge clk);
        // R1: forwarded layer and superstrip one cycle later
        chk(fwd_valid && fwd_layer == 2'(l) && fwd_ssid == SW'(s), "R1 forward",
            {fwd_valid, fwd_layer, fwd_ssid}, {1'b1, 2'(l), SW'(s)});
        hit_valid = 1'b0;
    endtask

    initial begin
        int exp_ovf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(road_ready == 1'b1, "R9 reset ready", road_ready, 1);
        chk(cand_valid == 1'b0, "R9 reset cand", cand_valid, 0);
        chk(fwd_valid == 1'b0, "R9 reset fwd", fwd_valid, 0);
        chk(ovf_count == '0, "R9 reset ovf", ovf_count, 0);

        // R2: program road table
        for (int r = 0; r < 8; r++) begin
            for (int l = 0; l < NL; l++) begin
                lut_we = 1'b1; lut_road = RW'(r); lut_layer = 2'(l); lut_ssid = SW'(lut_of(r, l));
                @(negedge clk);
            end
        end
        lut_we = 1'b0;
        exp_ovf = 0;

        for (int ev = 0; ev < 125; ev++) begin
            int n[NL];
            int k[NL];
            int e[NL];
            int total, got, guard, r;
            bit done;
            n[0] = ev % 5; n[1] = (ev / 5) % 5; n[2] = ev / 25;
            r = ev % 8;
            // R8: close previous event
            eoe = 1'b1;
            @(negedge clk);
            eoe = 1'b0;
            for (int i = 0; i < 5; i++) begin
                for (int l = 0; l < NL; l++) begin
                    if (i < n[l]) put_hit(l, lut_of(r, l), hd(ev, l, i));
                end
            end
            // R3: distractor hit in another superstrip of each layer
            for (int l = 0; l < NL; l++) put_hit(l, (lut_of(r, l) + 4) % 8, hd(ev, l, 7));
            total = 1;
            for (int l = 0; l < NL; l++) begin
                k[l] = (n[l] > LIM) ? LIM : n[l];
                e[l] = (k[l] == 0) ? 1 : k[l];
                total = total * e[l];
                if (n[l] > LIM) exp_ovf = exp_ovf + n[l] - LIM;
            end
            chk(road_ready == 1'b1, "R9 idle before road", road_ready, 1);
            road_valid = 1'b1;
            road_id = RW'(r);
            @(negedge clk);
            road_valid = 1'b0;
            chk(road_ready == 1'b0, "R9 busy after accept", road_ready, 0);
            got = 0; guard = 0; done = 1'b0;
            while (!done && guard < 300) begin
                if (cand_valid) begin
                    logic [NL*HW-1:0] eh;
                    logic [NL-1:0] em;
                    int rem;
                    rem = got;
                    eh = '0; em = '0;
                    for (int l = NL - 1; l >= 0; l--) begin
                        int ix;
                        ix = rem % e[l];
                        rem = rem / e[l];
                        if (k[l] == 0) em[l] = 1'b1;
                        else eh[l*HW +: HW] = hd(ev, l, k[l] - 1 - ix);
                    end
                    // R2 R3 R4 R5 R6: content, newest-first order, odometer order, placeholders
                    chk(cand_hits == eh && cand_miss == em && cand_last == (got == total - 1),
                        "R3/R4/R5/R6 candidate", {cand_last, cand_miss, cand_hits},
                        {(got == total - 1), em, eh});
                    got++;
                    if (cand_last) done = 1'b1;
                end
                guard++;
                if (!done) @(negedge clk);
            end
            // R5: number of candidates
            chk(got == total, "R5 candidate count", got, total);
            // R7: drop counter
            chk(int'(ovf_count) == exp_ovf, "R7 overflow count", ovf_count, exp_ovf);
            @(negedge clk);
            chk(road_ready == 1'b1, "R9 idle after last", road_ready, 1);
        end
        // R1: forward strobe falls without a hit
        chk(fwd_valid == 1'b0, "R1 forward idle", fwd_valid, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule